// File: doc/BRIEF.md
# Partitioned SIMD Multimedia ALU

This block is a 64-bit packed-data arithmetic unit. Each operand is treated as a row of independent lanes whose width is chosen per operation: eight bytes, four halfwords or two words. Carries never cross a lane edge. Besides lane-wise add, subtract and two compares, the unit narrows lanes with signed saturation (pack), widens them with sign extension (expand), and runs a pixel-distance operation. That operation adds the absolute differences of eight byte pairs into a 32-bit running total.

An operation is issued by raising `in_valid` for one cycle with the operands, opcode and lane size. Every operation goes through the same two-stage pipeline, so one can issue every cycle. `done` pulses with the result exactly two cycles later. A 16x16 block of 8-bit pixels is scored by clearing the total once and then issuing the pixel-distance operation 32 times, two per row. The last result is the block sum.

Top module: `simd_alu`

## Requirements
- R1: Opcode 0 adds lane by lane, modulo the lane width, with no carry into the next lane. Lane size 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes.
- R2: Opcode 1 subtracts `in_b` from `in_a` lane by lane, modulo the lane width, with no borrow across lanes.
- R3: Opcode 2 sets every bit of a lane to 1 when the two lanes are equal and to 0 otherwise.
- R4: Opcode 3 sets a lane to all ones when the `in_a` lane is greater than the `in_b` lane as signed numbers, and to all zeros otherwise.
- R5: Opcode 4 (pack) clamps each signed lane of width w (16 or 32) to the signed range of w/2 bits and keeps the low w/2 bits. The lanes of `in_a` fill the low 32 result bits and the lanes of `in_b` fill the high 32 bits, each in lane order. With lane size 0 the result is zero.
- R6: Opcode 5 (expand) takes the lanes in the low 32 bits of `in_a`, sign-extends each to twice its width and places them in lane order. For 32-bit lanes this gives one 64-bit value.
- R7: Opcode 6 (pixel distance) adds the sum of the eight byte-wise unsigned absolute differences of `in_a` and `in_b` to the accumulator. The result is the new accumulator value, zero-extended to 64 bits.
- R8: Opcode 7 clears the accumulator and returns a zero result.
- R9: `done` is high in the second cycle after the cycle in which `in_valid` is sampled, for one cycle per operation, and never otherwise. Operations may be issued on consecutive cycles.
- R10: During and just after reset, `done` is low and the accumulator is zero.
- R11: Thirty-two pixel-distance operations over bytes of 255 against 0, after a clear, leave a total of 65280 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issues one operation this cycle |
| in_op | input | 3 | Opcode 0..7 |
| in_sz | input | 2 | Lane size select |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| done | output | 1 | Result valid pulse |
| res | output | 64 | Packed result |

## Verification
Every result, including the accumulator update, is due two rising edges after the edge that samples `in_valid`. The bench drives on a falling edge, checks at the next falling edge that `done` is still low, and samples `done` and `res` at the falling edge after that. The pipelined test issues three operations on consecutive cycles and checks each at its own falling edge. This confirms that results do not interfere and that the accumulator chains correctly when operations follow each other without a gap.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DW   = 64;
  localparam int ACCW = 32;
  localparam int PIXW = 8;
  localparam int NPIX = DW / PIXW;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_CEQ = 3'd2, OP_CGT = 3'd3,
    OP_PACK = 3'd4, OP_EXPD = 3'd5, OP_SAD = 3'd6, OP_SCLR = 3'd7
  } op_e;

  function automatic int lane_bits(input logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [DW-1:0] lmask(input int w);
    return (w >= DW) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [DW-1:0] sext(input logic [DW-1:0] v, input int w);
    logic [DW-1:0] sb;
    sb = 64'd1 << (w - 1);
    return ((v & lmask(w)) ^ sb) - sb;
  endfunction

  // ripple chain with the carry re-seeded at each lane start
  function automatic logic [DW-1:0] f_addsub(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                             input int w, input logic sub);
    logic [DW-1:0] r;
    logic c, bb;
    c = 1'b0;
    for (int k = 0; k < DW; k++) begin
      if (k % w == 0) c = sub;
      bb   = b[k] ^ sub;
      r[k] = a[k] ^ bb ^ c;
      c    = (a[k] & bb) | (a[k] & c) | (bb & c);
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] f_cmp(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                          input int w, input logic gt);
    logic [DW-1:0] r, la, lb, sb;
    logic hit;
    r  = '0;
    sb = 64'd1 << (w - 1);
    for (int l = 0; l < DW / w; l++) begin
      la  = (a >> (l * w)) & lmask(w);
      lb  = (b >> (l * w)) & lmask(w);
      hit = gt ? ((la ^ sb) > (lb ^ sb)) : (la == lb);
      if (hit) r = r | (lmask(w) << (l * w));
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] f_pack(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input int w);
    logic [DW-1:0] r, v;
    logic signed [DW-1:0] sv, hi, lo;
    int h;
    r = '0;
    if (w < 16) return r;
    h  = w / 2;
    hi = $signed((64'd1 << (h - 1)) - 64'd1);
    lo = -hi - 64'sd1;
    for (int s = 0; s < 2; s++) begin
      for (int l = 0; l < DW / w; l++) begin
        v  = (s == 0) ? (a >> (l * w)) : (b >> (l * w));
        sv = $signed(sext(v, w));
        if (sv > hi) sv = hi;
        if (sv < lo) sv = lo;
        r = r | ((64'(sv) & lmask(h)) << (s * (DW / 2) + l * h));
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] f_expand(input logic [DW-1:0] a, input int w);
    logic [DW-1:0] r;
    r = '0;
    for (int l = 0; l < DW / (2 * w); l++)
      r = r | ((sext(a >> (l * w), w) & lmask(2 * w)) << (l * 2 * w));
    return r;
  endfunction

  function automatic logic [PIXW-1:0] f_absdiff(input logic [PIXW-1:0] x, input logic [PIXW-1:0] y);
    return (x > y) ? x - y : y - x;
  endfunction
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_pkg::*;
(
  input  op_e             op,
  input  logic [1:0]      sz,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y
);
  int w;
  always_comb begin
    w = lane_bits(sz);
    case (op)
      OP_ADD:  y = f_addsub(a, b, w, 1'b0);
      OP_SUB:  y = f_addsub(a, b, w, 1'b1);
      OP_CEQ:  y = f_cmp(a, b, w, 1'b0);
      OP_CGT:  y = f_cmp(a, b, w, 1'b1);
      OP_PACK: y = f_pack(a, b, w);
      OP_EXPD: y = f_expand(a, w);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_sad_absdiff.sv
module simd_sad_absdiff
  import simd_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] diffs
);
  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    assign diffs[p*PIXW +: PIXW] = f_absdiff(a[p*PIXW +: PIXW], b[p*PIXW +: PIXW]);
  end
endmodule

// File: rtl/simd_sad_accum.sv
module simd_sad_accum
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sad_en,
  input  logic              clr_en,
  input  logic [DW-1:0]     diffs,
  output logic [ACCW-1:0]   acc,
  output logic [ACCW-1:0]   acc_nxt
);
  localparam int SUMW = PIXW + $clog2(NPIX);
  localparam int MAXSUM = NPIX * ((1 << PIXW) - 1);

  logic [SUMW-1:0] row_sum;
  always_comb begin
    row_sum = '0;
    for (int p = 0; p < NPIX; p++) row_sum = row_sum + SUMW'(diffs[p*PIXW +: PIXW]);
  end

  always_comb begin
    if (clr_en)      acc_nxt = '0;
    else if (sad_en) acc_nxt = acc + ACCW'(row_sum);
    else             acc_nxt = acc;
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc_nxt;
  end

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    sad_en && !clr_en |=> (acc - $past(acc)) <= ACCW'(MAXSUM)); // R7
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> acc == '0); // R8
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_sz,
  input  logic [63:0]   in_a,
  input  logic [63:0]   in_b,
  output logic          done,
  output logic [63:0]   res
);
  op_e             op_in;
  logic [DW-1:0]   lane_y, diffs;
  logic            s1_vld;
  op_e             s1_op;
  logic [DW-1:0]   s1_y, s1_ad;
  logic            sad_en, clr_en;
  logic [ACCW-1:0] acc, acc_nxt;

  assign op_in = op_e'(in_op);

  simd_lane_unit u_lane (.op(op_in), .sz(in_sz), .a(in_a), .b(in_b), .y(lane_y));
  simd_sad_absdiff u_abs (.a(in_a), .b(in_b), .diffs(diffs));

  // stage 1: lane result and byte differences
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_op  <= OP_ADD;
      s1_y   <= '0;
      s1_ad  <= '0;
    end else begin
      s1_vld <= in_valid;
      s1_op  <= op_in;
      s1_y   <= lane_y;
      s1_ad  <= diffs;
    end
  end

  assign sad_en = s1_vld && (s1_op == OP_SAD);
  assign clr_en = s1_vld && (s1_op == OP_SCLR);

  simd_sad_accum u_acc (.clk(clk), .rst(rst), .sad_en(sad_en), .clr_en(clr_en),
                        .diffs(s1_ad), .acc(acc), .acc_nxt(acc_nxt));

  // stage 2: reduction/accumulate and result register
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      res  <= '0;
    end else begin
      done <= s1_vld;
      if (s1_vld) begin
        case (s1_op)
          OP_SAD:  res <= {{(DW-ACCW){1'b0}}, acc_nxt};
          OP_SCLR: res <= '0;
          default: res <= s1_y;
        endcase
      end
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 done); // R9
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(s1_vld)); // R9
  AST_ADD_ZERO_IDENT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_op == 3'd0 && in_b == 64'd0 |-> ##2 res == $past(in_a, 2)); // R1
  AST_EQ_SELF_ONES: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_op == 3'd2 && in_a == in_b |-> ##2 res == '1); // R3
endmodule

// File: tb/simd_alu_tb.sv
module simd_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic [1:0]  in_sz = 2'd0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        done;
  logic [63:0] res;
  int          n_run = 0, n_fail = 0;
  logic [31:0] model_acc = '0;

  always #5 clk = ~clk;

  simd_alu u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_sz(in_sz),
                  .in_a(in_a), .in_b(in_b), .done(done), .res(res));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wsel(input logic [1:0] sz);
    case (sz) 2'd0: return 8; 2'd1: return 16; default: return 32; endcase
  endfunction

  function automatic longint sval(input logic [63:0] v, input int w, input int l);
    longint x;
    x = longint'((v >> (l * w)) & ((64'd1 << w) - 1));
    if (x >= (longint'(1) << (w - 1))) x = x - (longint'(1) << w);
    return x;
  endfunction

  function automatic logic [63:0] ref_op(input logic [2:0] op, input logic [1:0] sz,
                                         input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r, m;
    longint x, y, lim;
    int w;
    w = wsel(sz);
    r = '0;
    m = (64'd1 << w) - 1;
    case (op)
      3'd0, 3'd1, 3'd2, 3'd3:
        for (int l = 0; l < 64 / w; l++) begin
          x = sval(a, w, l); y = sval(b, w, l);
          case (op)
            3'd0: r = r | ((64'(x + y) & m) << (l * w));
            3'd1: r = r | ((64'(x - y) & m) << (l * w));
            3'd2: if (x == y) r = r | (m << (l * w));
            default: if (x > y) r = r | (m << (l * w));
          endcase
        end
      3'd4:
        if (w > 8) begin
          lim = longint'(1) << (w / 2 - 1);
          for (int l = 0; l < 64 / w; l++) begin
            x = sval(a, w, l); y = sval(b, w, l);
            x = (x >= lim) ? lim - 1 : (x < -lim) ? -lim : x;
            y = (y >= lim) ? lim - 1 : (y < -lim) ? -lim : y;
            r = r | ((64'(x) & ((64'd1 << (w / 2)) - 1)) << (l * w / 2));
            r = r | ((64'(y) & ((64'd1 << (w / 2)) - 1)) << (32 + l * w / 2));
          end
        end
      3'd5:
        for (int l = 0; l < 32 / w; l++) begin
          x = sval(a, w, l);
          r = (w == 32) ? 64'(x) : (r | ((64'(x) & ((64'd1 << (2 * w)) - 1)) << (l * 2 * w)));
        end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic int ref_sad(input logic [63:0] a, input logic [63:0] b);
    int s, x, y;
    s = 0;
    for (int p = 0; p < 8; p++) begin
      x = int'(a[p*8 +: 8]); y = int'(b[p*8 +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return s;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [1:0] sz,
                       input logic [63:0] a, input logic [63:0] b, output logic [63:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_sz = sz; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 done early", {63'd0, done}, 64'd0);
    @(negedge clk);
    check("R9 done due", {63'd0, done}, 64'd1);
    r = res;
  endtask

  task automatic run_lane(input string req, input logic [2:0] op, input logic [1:0] sz,
                          input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    issue(op, sz, a, b, r);
    check(req, r, ref_op(op, sz, a, b));
  endtask

  task automatic t_reset();
    logic [63:0] r;
    check("R10 done in reset", {63'd0, done}, 64'd0);
    @(negedge clk); rst = 1'b0;
    check("R10 done after reset", {63'd0, done}, 64'd0);
    issue(3'd6, 2'd0, '0, '0, r);
    check("R10 acc zero", r, 64'd0);
  endtask

  task automatic t_add();
    run_lane("R1 add bytes carry break", 3'd0, 2'd0, 64'hFF80_7F01_FFFF_0001, 64'h0180_0101_0001_FFFF);
    run_lane("R1 add halves", 3'd0, 2'd1, 64'hFFFF_8000_7FFF_1234, 64'h0001_8000_0001_1111);
    run_lane("R1 add words", 3'd0, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF);
    run_lane("R1 add size3", 3'd0, 2'd3, 64'h8000_0000_7FFF_FFFF, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_sub();
    run_lane("R2 sub bytes borrow", 3'd1, 2'd0, 64'h0001_0203_8000_10FF, 64'h0102_0304_0180_2001);
    run_lane("R2 sub halves", 3'd1, 2'd1, 64'h0000_8000_1234_0005, 64'h0001_0001_1234_0006);
    run_lane("R2 sub words", 3'd1, 2'd2, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0006);
  endtask

  task automatic t_cmp();
    run_lane("R3 eq bytes", 3'd2, 2'd0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788);
    run_lane("R3 eq halves", 3'd2, 2'd1, 64'h1122_3344_5566_7788, 64'h1122_3345_5566_0000);
    run_lane("R4 gt bytes signed", 3'd3, 2'd0, 64'h7F80_0001_FF05_8000, 64'h807F_FF01_0004_7F00);
    run_lane("R4 gt words signed", 3'd3, 2'd2, 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF);
  endtask

  task automatic t_pack_expand();
    run_lane("R5 pack halves sat", 3'd4, 2'd1, 64'h0100_FF00_0005_FFFD, 64'h007F_FF80_7FFF_8000);
    run_lane("R5 pack words sat", 3'd4, 2'd2, 64'h0001_0000_FFFF_7000, 64'h0000_1234_FFFF_FFFF);
    run_lane("R5 pack bytes zero", 3'd4, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444);
    run_lane("R6 expand bytes", 3'd5, 2'd0, 64'hDEAD_BEEF_807F_01FF, 64'h0);
    run_lane("R6 expand halves", 3'd5, 2'd1, 64'h0000_0000_8001_7FFF, 64'h0);
    run_lane("R6 expand word", 3'd5, 2'd2, 64'h1234_5678_8000_0001, 64'h0);
  endtask

  task automatic t_sad();
    logic [63:0] r;
    issue(3'd7, 2'd0, 64'hFFFF, 64'h1, r);
    check("R8 clear result", r, 64'd0);
    model_acc = '0;
    issue(3'd6, 2'd0, 64'h1080_00FF_7F01_C820, 64'h2070_FF00_8001_20C8, r);
    model_acc += 32'(ref_sad(64'h1080_00FF_7F01_C820, 64'h2070_FF00_8001_20C8));
    check("R7 sad first", r, {32'd0, model_acc});
    issue(3'd6, 2'd1, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, r);
    model_acc += 32'(ref_sad(64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201));
    check("R7 sad accumulate", r, {32'd0, model_acc});
    issue(3'd7, 2'd0, '0, '0, r);
    issue(3'd6, 2'd0, 64'h0000_0000_0000_0003, '0, r);
    check("R8 acc restarts after clear", r, 64'd3);
  endtask

  task automatic t_block();
    logic [63:0] r;
    issue(3'd7, 2'd0, '0, '0, r);
    for (int i = 0; i < 32; i++) issue(3'd6, 2'd0, '1, '0, r);
    check("R11 block total", r, 64'd65280);
  endtask

  task automatic t_pipeline();
    logic [63:0] e0, e1;
    e0 = ref_op(3'd0, 2'd0, 64'h0101_0101_0101_01FF, 64'h0101_0101_0101_0101);
    e1 = ref_op(3'd3, 2'd1, 64'h0001_FFFF_0002_8000, 64'h0000_0000_0002_7FFF);
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd0; in_sz = 2'd0; in_a = 64'h0101_0101_0101_01FF; in_b = 64'h0101_0101_0101_0101;
    @(negedge clk);
    in_op = 3'd3; in_sz = 2'd1; in_a = 64'h0001_FFFF_0002_8000; in_b = 64'h0000_0000_0002_7FFF;
    @(negedge clk);
    in_op = 3'd6; in_sz = 2'd0; in_a = 64'h0000_0000_0000_0010; in_b = '0;
    check("R9 back-to-back first done", {63'd0, done}, 64'd1);
    check("R9 back-to-back first", res, e0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 back-to-back second", res, e1);
    @(negedge clk);
    check("R9 back-to-back sad", res, 64'd65296);
    @(negedge clk);
    check("R9 single pulse", {63'd0, done}, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_pack_expand();
    t_sad();
    t_block();
    t_pipeline();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule